// File: doc/BRIEF.md
# Masked Sparse Prefetch Address Sequencer

This block takes one vector scatter-prefetch operation and turns it into a series of cache prefetch requests, one per active element. An operation is made of a base address, a 512-bit packed index vector, a 16-bit write mask, a 2-bit scale code, a 32-bit displacement and a 2-bit variant code. The variant code chooses 32-bit or 64-bit indices and single or double precision data. For each element whose mask bit is set, the block forms base + sign-extended index shifted by the scale + sign-extended displacement. It then presents that address on a valid/ready request port.

Every request carries a level-2 cache hint and an exclusive-ownership flag. Requests can never fault, and the mask that was handed in comes back unchanged on a mask output. A single-cycle done pulse closes each operation. The block takes a new operation only while it is idle.

Top module: `spf_top`

## Requirements
- R1: For each request, reqAddr equals opBase + (sign-extended index << opScale) + sign-extended opDisp, modulo 2^64. opScale code 0,1,2,3 means x1, x2, x4, x8.
- R2: A request is issued for element j only when opMask bit j is set. No request appears without an active element behind it.
- R3: Variant code 0 (32-bit index, single data) covers 16 elements. Element j takes its index from opIndex[32j+31:32j].
- R4: Variant code 1 (32-bit index, double data) covers 8 elements with indices from opIndex[32j+31:32j]. Mask bits 15:8 and opIndex[511:256] have no effect on the requests.
- R5: Variant codes 2 and 3 (64-bit index) cover 8 elements with indices from opIndex[64j+63:64j]. Mask bits 15:8 have no effect.
- R6: Every request has reqLevel = 1 (second-level cache) and reqExcl = 1 (read for ownership).
- R7: maskOut holds the full 16-bit mask of the last accepted operation and does not change until the next operation is accepted.
- R8: Requests leave in ascending element order, one per cycle while reqReady is high. While reqValid is high and reqReady is low, reqValid stays high and reqAddr stays stable.
- R9: An operation with no active element raises opDone in the cycle after acceptance and issues no request.
- R10: opDone is a one-cycle pulse in the cycle after the final request handshake. opReady is low while busy, and opValid is ignored while busy.
- R11: After reset, opReady = 1, reqValid = 0 and opDone = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offered |
| opReady | output | 1 | Block idle; operation taken when opValid is high |
| opVariant | input | 2 | Bit 1: 64-bit indices; bit 0: double data |
| opBase | input | 64 | Base address |
| opIndex | input | 512 | Packed index vector |
| opMask | input | 16 | Element write mask |
| opScale | input | 2 | Scale code (left shift amount) |
| opDisp | input | 32 | Signed displacement |
| reqValid | output | 1 | Prefetch request valid |
| reqReady | input | 1 | Request accepted by the cache side |
| reqAddr | output | 64 | Element address |
| reqLevel | output | 2 | Target cache level (always 1) |
| reqExcl | output | 1 | Read-for-ownership flag (always 1) |
| opDone | output | 1 | Operation complete pulse |
| maskOut | output | 16 | Mask of the last accepted operation |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle, because the block turns idle exactly when opDone rises. The bench runs short operations back to back with reqReady held high, so the driver offers the next operation in the done cycle. It then requires that at least one acceptance saw opDone high. The scoreboard must also see the second operation's addresses follow without loss or duplication, and the done count must equal the number of operations offered.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int VEC_W   = 512;
  localparam int MASK_W  = 16;
  localparam int DW_W    = 32;
  localparam int QW_W    = 64;
  localparam int DW_LANES = VEC_W / DW_W;
  localparam int QW_LANES = VEC_W / QW_W;
  localparam int SEL_W   = $clog2(MASK_W);

  typedef enum logic [1:0] {
    VAR_D_SP = 2'd0,
    VAR_D_DP = 2'd1,
    VAR_Q_SP = 2'd2,
    VAR_Q_DP = 2'd3
  } variant_e;

  typedef struct packed {
    logic             load;
    logic [SEL_W-1:0] elemSel;
  } strobe_t;

  localparam logic [1:0] HINT_LEVEL = 2'd1;
endpackage

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int NUM_BITS = MASK_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [1:0]          opVariant,
  input  logic [NUM_BITS-1:0] opMask,
  input  logic                reqReady,
  output logic                opReady,
  output logic                reqValid,
  output logic                opDone,
  output strobe_t             strobes
);
  localparam int HALF = NUM_BITS / 2;
  localparam logic [NUM_BITS-1:0] FULL_LIMIT = {NUM_BITS{1'b1}};
  localparam logic [NUM_BITS-1:0] HALF_LIMIT = {{(NUM_BITS-HALF){1'b0}}, {HALF{1'b1}}};

  logic                busy;
  logic                doneQ;
  logic [NUM_BITS-1:0] pend;
  logic [NUM_BITS-1:0] nextPend;
  logic [NUM_BITS-1:0] effMask;
  logic [SEL_W-1:0]    sel;
  logic                accept;
  logic                fire;

  assign accept  = opValid && !busy;
  assign fire    = busy && reqReady;
  assign effMask = opMask & ((opVariant == VAR_D_SP) ? FULL_LIMIT : HALF_LIMIT);

  always_comb begin
    sel = '0;
    for (int i = NUM_BITS - 1; i >= 0; i--) begin
      if (pend[i]) sel = SEL_W'(i);
    end
  end

  always_comb begin
    nextPend = pend;
    nextPend[sel] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      doneQ <= 1'b0;
      pend  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        pend  <= effMask;
        busy  <= |effMask;
        doneQ <= ~|effMask;
      end else if (fire) begin
        pend <= nextPend;
        if (nextPend == '0) begin
          busy  <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign opReady         = !busy;
  assign reqValid        = busy;
  assign opDone          = doneQ;
  assign strobes.load    = accept;
  assign strobes.elemSel = sel;
endmodule

// File: rtl/spf_dpath.sv
module spf_dpath
  import spf_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [1:0]        opVariant,
  input  logic [ADDR_W-1:0] opBase,
  input  logic [VEC_W-1:0]  opIndex,
  input  logic [MASK_W-1:0] opMask,
  input  logic [1:0]        opScale,
  input  logic [DISP_W-1:0] opDisp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [MASK_W-1:0] maskOut
);
  logic [ADDR_W-1:0] baseQ;
  logic [VEC_W-1:0]  idxQ;
  logic [MASK_W-1:0] maskQ;
  logic [1:0]        scaleQ;
  logic [DISP_W-1:0] dispQ;
  logic              qwordQ;

  logic [DW_W-1:0]   dwLane [DW_LANES];
  logic [QW_W-1:0]   qwLane [QW_LANES];
  logic [ADDR_W-1:0] idxExt;
  logic [ADDR_W-1:0] dispExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      idxQ   <= '0;
      maskQ  <= '0;
      scaleQ <= '0;
      dispQ  <= '0;
      qwordQ <= 1'b0;
    end else if (strobes.load) begin
      baseQ  <= opBase;
      idxQ   <= opIndex;
      maskQ  <= opMask;
      scaleQ <= opScale;
      dispQ  <= opDisp;
      qwordQ <= opVariant[1];
    end
  end

  for (genvar g = 0; g < DW_LANES; g++) begin : gDword
    assign dwLane[g] = idxQ[g*DW_W +: DW_W];
  end
  for (genvar g = 0; g < QW_LANES; g++) begin : gQword
    assign qwLane[g] = idxQ[g*QW_W +: QW_W];
  end

  always_comb begin
    if (qwordQ)
      idxExt = ADDR_W'(qwLane[strobes.elemSel[SEL_W-2:0]]);
    else
      idxExt = {{(ADDR_W-DW_W){dwLane[strobes.elemSel][DW_W-1]}}, dwLane[strobes.elemSel]};
  end

  assign dispExt = {{(ADDR_W-DISP_W){dispQ[DISP_W-1]}}, dispQ};
  assign reqAddr = baseQ + (idxExt << scaleQ) + dispExt;
  assign maskOut = maskQ;
endmodule

// File: rtl/spf_top.sv
module spf_top
  import spf_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic [1:0]        opVariant,
  input  logic [ADDR_W-1:0] opBase,
  input  logic [VEC_W-1:0]  opIndex,
  input  logic [MASK_W-1:0] opMask,
  input  logic [1:0]        opScale,
  input  logic [DISP_W-1:0] opDisp,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqLevel,
  output logic              reqExcl,
  output logic              opDone,
  output logic [MASK_W-1:0] maskOut
);
  strobe_t strobes;

  spf_ctrl #(.NUM_BITS(MASK_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opVariant(opVariant),
    .opMask   (opMask),
    .reqReady (reqReady),
    .opReady  (opReady),
    .reqValid (reqValid),
    .opDone   (opDone),
    .strobes  (strobes)
  );

  spf_dpath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opVariant(opVariant),
    .opBase   (opBase),
    .opIndex  (opIndex),
    .opMask   (opMask),
    .opScale  (opScale),
    .opDisp   (opDisp),
    .reqAddr  (reqAddr),
    .maskOut  (maskOut)
  );

  assign reqLevel = HINT_LEVEL;
  assign reqExcl  = 1'b1;
endmodule

// File: rtl/spf_checker.sv
module spf_checker (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic        opReady,
  input logic [15:0] opMask,
  input logic        reqValid,
  input logic        reqReady,
  input logic [63:0] reqAddr,
  input logic        opDone,
  input logic [15:0] maskOut
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !opReady); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> (opReady && !reqValid)); // R10
  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !opReady |=> $stable(maskOut)); // R7
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opReady && opMask == 16'h0) |=> (opDone && !reqValid)); // R9
endmodule

bind spf_top spf_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opReady (opReady),
  .opMask  (opMask),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqAddr (reqAddr),
  .opDone  (opDone),
  .maskOut (maskOut)
);

// File: tb/spf_top_tb_top.sv
module spf_top_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic         opReady;
  logic [1:0]   opVariant = '0;
  logic [63:0]  opBase = '0;
  logic [511:0] opIndex = '0;
  logic [15:0]  opMask = '0;
  logic [1:0]   opScale = '0;
  logic [31:0]  opDisp = '0;
  logic         reqValid;
  logic         reqReady = 1'b0;
  logic [63:0]  reqAddr;
  logic [1:0]   reqLevel;
  logic         reqExcl;
  logic         opDone;
  logic [15:0]  maskOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int opsOffered = 0;
  int doneCount = 0;
  bit readyRandom = 0;
  bit expectDone = 0;
  bit holdPending = 0;
  logic [63:0] holdAddr;
  logic [15:0] lfsr = 16'hACE1;
  logic [63:0] expQ[$];

  always #2 clk = ~clk;

  spf_top dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opVariant(opVariant), .opBase(opBase), .opIndex(opIndex), .opMask(opMask),
    .opScale(opScale), .opDisp(opDisp), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLevel(reqLevel), .reqExcl(reqExcl), .opDone(opDone),
    .maskOut(maskOut)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expAddr(input logic [63:0] b, input logic [511:0] ix, input int j,
                                          input logic [1:0] sc, input logic [31:0] d, input logic [1:0] v);
    longint signed e;
    longint signed dd;
    if (v[1]) e = $signed(ix[64*j +: 64]);
    else      e = $signed(ix[32*j +: 32]);
    dd = $signed(d);
    return b + 64'(e * (longint'(1) << sc)) + 64'(dd);
  endfunction

  function automatic logic [511:0] mkDw(input int seed);
    logic [511:0] v;
    for (int j = 0; j < 16; j++) v[32*j +: 32] = 32'(seed * (j + 1) - 700 * j);
    return v;
  endfunction

  function automatic logic [511:0] mkQw(input longint seed);
    logic [511:0] v;
    for (int j = 0; j < 8; j++) v[64*j +: 64] = 64'(seed - longint'(j) * 64'h0000_0100_0000_0003);
    return v;
  endfunction

  // Driver: offers one operation and pushes its expected addresses.
  task automatic runOp(input logic [63:0] b, input logic [511:0] ix, input logic [15:0] m,
                       input logic [1:0] sc, input logic [31:0] d, input logic [1:0] v,
                       output bit sawDone);
    int n;
    int act;
    @(negedge clk);
    while (!opReady) @(negedge clk);
    sawDone = opDone;
    n = (v == 2'd0) ? 16 : 8;
    act = 0;
    for (int j = 0; j < n; j++) begin
      if (m[j]) begin
        expQ.push_back(expAddr(b, ix, j, sc, d, v));
        act++;
      end
    end
    opsOffered++;
    opBase = b; opIndex = ix; opMask = m; opScale = sc; opDisp = d; opVariant = v;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    if (act == 0) begin
      chk(opDone && !reqValid, "R9 empty op done at once", {62'b0, opDone, reqValid}, 64'h2);
    end
  endtask

  task automatic waitIdle(input logic [15:0] m);
    while (!(opReady && expQ.size() == 0 && !opDone)) @(negedge clk);
    chk(maskOut == m, "R7 mask returned unchanged", 64'(maskOut), 64'(m));
  endtask

  // Monitor: chooses reqReady and compares handshakes against the queue.
  always @(negedge clk) begin
    bit r;
    logic [63:0] e;
    if (rstN) begin
      if (expectDone) begin
        chk(opDone, "R10 done one cycle after last request", 64'(opDone), 64'h1);
        expectDone = 0;
      end
      if (opDone) doneCount++;
      r = readyRandom ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (holdPending) begin
        chk(reqValid && reqAddr == holdAddr, "R8 request held while stalled", reqAddr, holdAddr);
        holdPending = 0;
      end
      if (reqValid) begin
        if (!r) begin
          holdPending = 1;
          holdAddr = reqAddr;
        end else if (expQ.size() == 0) begin
          chk(0, "R2 request without active element", reqAddr, 64'h0);
        end else begin
          e = expQ.pop_front();
          chk(reqAddr == e, "R1 R8 element address in order", reqAddr, e);
          chk(reqLevel == 2'd1 && reqExcl, "R6 level-2 exclusive hint", {61'b0, reqLevel, reqExcl}, 64'h3);
          if (expQ.size() == 0) expectDone = 1;
        end
      end
      reqReady = r;
    end
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit sd;
    bit anyOverlap;
    logic [511:0] ix;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(opReady && !reqValid && !opDone, "R11 reset state", {61'b0, opReady, reqValid, opDone}, 64'h4);

    // R3: 16 x 32-bit indices, full mask, scale x4
    runOp(64'h0000_1000_0000_0000, mkDw(-513), 16'hFFFF, 2'd2, 32'h0000_0040, 2'd0, sd);
    waitIdle(16'hFFFF);

    // R4: 32-bit indices with double data; upper mask and upper index bits ignored
    ix = mkDw(999);
    ix[511:256] = {8{32'hDEAD_BEEF}};
    runOp(64'h0000_0000_8000_0000, ix, 16'hFF5A, 2'd3, 32'hFFFF_FF00, 2'd1, sd);
    waitIdle(16'hFF5A);

    // R5 R2: 64-bit indices, sparse mask, negative displacement, scale x1
    runOp(64'h7FFF_0000_0000_0000, mkQw(-64'sd12345), 16'h00A5, 2'd0, 32'h8000_0000, 2'd2, sd);
    waitIdle(16'h00A5);

    // R5: variant 3, scale x2, upper mask bits ignored
    runOp(64'h0000_0000_0000_1234, mkQw(64'sd777), 16'h8181, 2'd1, 32'h0000_0010, 2'd3, sd);
    waitIdle(16'h8181);

    // R5 R9: only ignored mask bits set on an 8-element variant
    runOp(64'h1, mkQw(5), 16'hFF00, 2'd0, 32'h0, 2'd3, sd);
    waitIdle(16'hFF00);

    // R9: all-zero mask
    runOp(64'h2, mkDw(7), 16'h0000, 2'd1, 32'h0, 2'd0, sd);
    waitIdle(16'h0000);

    // R8 R10: random stalls, busy-time opValid ignored
    readyRandom = 1;
    runOp(64'h0000_0042_0000_0000, mkDw(31337), 16'h6E3B, 2'd1, 32'h0000_0100, 2'd0, sd);
    opBase = 64'hFFFF_FFFF_FFFF_FFFF; opMask = 16'h0001; opVariant = 2'd3;
    opValid = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (reqValid) chk(!opReady, "R10 not ready while busy", 64'(opReady), 64'h0);
    end
    opValid = 1'b0;
    chk(maskOut == 16'h6E3B, "R10 busy opValid ignored", 64'(maskOut), 64'h6E3B);
    waitIdle(16'h6E3B);
    readyRandom = 0;

    // R10: back-to-back operations, done and accept in one cycle
    anyOverlap = 0;
    for (int k = 0; k < 4; k++) begin
      runOp(64'h1000 * (k + 1), mkDw(k * 11 - 3), 16'h0003 << k, 2'(k), 32'(k * 8), 2'd0, sd);
      if (sd) anyOverlap = 1;
    end
    waitIdle(16'h0018);
    chk(anyOverlap, "R10 accept in done cycle", 64'(anyOverlap), 64'h1);

    repeat (3) @(negedge clk);
    chk(doneCount == opsOffered, "R10 one done per operation", 64'(doneCount), 64'(opsOffered));
    chk(expQ.size() == 0, "R2 all expected requests seen", 64'(expQ.size()), 64'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule